// File: doc/BRIEF.md
# Gated Multi-Function Execute Unit

This block is the execute stage of a small in-order pipeline. Each cycle it takes two 16-bit operands. Each operand comes either from a register-file read port or from an immediate field carried with the instruction, chosen by its own select bit. From those operands it forms a bitwise AND, OR and XOR, a sum, and a signed product. A result multiplexer keeps only the result named by the 3-bit operation code. The chosen result, a valid flag and the 3-bit destination register tag are captured in an output register. Writeback reads that register one clock later.

The sum is built on a 32-bit ripple-carry chain fed with sign-extended operands. The product uses only the low byte of each operand, taken as a two's-complement number. The value written back is the low 16 bits of either. A clock-enable input gates the output register: while it is low, the result, the tag and the valid flag all keep their previous values. Operation codes outside the five defined ones act as no-operation slots. They produce a cleared result and a cleared valid flag.

Top module: `exu_top`

## Requirements
- R1: Operation code 0 returns the bitwise AND of the two selected operands.
- R2: Operation code 1 returns the bitwise OR of the two selected operands.
- R3: Operation code 2 returns the bitwise XOR of the two selected operands.
- R4: Operation code 3 returns the low 16 bits of the two's-complement sum of the selected operands, wrapping silently (0xFFFF + 0x0001 gives 0x0000).
- R5: Operation code 4 returns the low 16 bits of the signed product of bits [7:0] of each selected operand; bits [15:8] of either operand have no effect on this result.
- R6: When an operand's immediate select is 1 that operand is its immediate input and the register input has no effect; when the select is 0 the register input is used.
- R7: With the enable high, the result, the valid flag and the tag reflect the inputs from the previous rising clock edge, and the valid flag is 1 for codes 0 to 4.
- R8: Codes 5, 6 and 7 are no-operation slots: with the enable high they load a result of 0x0000 and a valid flag of 0.
- R9: With the enable low, the result, the tag and the valid flag keep their values, whatever the other inputs do.
- R10: The destination tag loaded with each result equals the tag presented with that instruction, for every code including the no-operation slots.
- R11: While the reset input is low, the result, the tag and the valid flag are all zero. The reset takes effect at once and is released on the clock; outputs start to follow the inputs on the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Clock enable for the output register |
| op_i | input | 3 | Operation code: 0 AND, 1 OR, 2 XOR, 3 ADD, 4 MUL, 5-7 no-operation |
| rs_a_i | input | 16 | Register-file value for operand A |
| imm_a_i | input | 16 | Immediate value for operand A |
| use_imm_a_i | input | 1 | 1 selects the immediate for operand A |
| rs_b_i | input | 16 | Register-file value for operand B |
| imm_b_i | input | 16 | Immediate value for operand B |
| use_imm_b_i | input | 1 | 1 selects the immediate for operand B |
| dst_i | input | 3 | Destination register tag of the instruction |
| res_o | output | 16 | Registered result |
| dst_o | output | 3 | Registered destination tag |
| vld_o | output | 1 | Registered valid flag for writeback |

## Verification
The gated hold and the arrival of a fresh operation can fall in the same cycle. The bench provokes this by presenting new, legal operations with changed tags while the enable is low. Both a valid result and an earlier no-operation slot are held this way. The results and tags must match the last enabled instruction, not the one on the inputs. An asynchronous reset is also asserted in the middle of a run, over a held valid result, and all three outputs must read zero before the next clock edge.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned TAG_W  = 3;
  localparam int unsigned SUM_W  = 32;
  localparam int unsigned MUL_W  = 8;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_ADD = 3'd3,
    OP_MUL = 3'd4
  } exu_op_e;
endpackage

// File: rtl/exu_rst_sync.sv
module exu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] reg_val_i,
  input  logic [W-1:0] imm_val_i,
  input  logic         use_imm_i,
  output logic [W-1:0] opnd_o
);
  always_comb begin
    if (use_imm_i) opnd_o = imm_val_i;
    else           opnd_o = reg_val_i;
  end
endmodule

// File: rtl/exu_logic_unit.sv
module exu_logic_unit #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o
);
  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    xor_o = a_i ^ b_i;
  end
endmodule

// File: rtl/exu_ripple_adder.sv
module exu_ripple_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/exu_signed_mult.sv
module exu_signed_mult #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] acc [W+1];

  assign a_ext  = {{W{a_i[W-1]}}, a_i};
  assign acc[0] = '0;

  // Shift-add over the multiplier bits; the top bit carries negative weight.
  for (genvar i = 0; i < W; i++) begin : g_pp
    logic [PW-1:0] pp;
    assign pp = b_i[i] ? (a_ext << i) : '0;
    if (i == W - 1) begin : g_neg
      assign acc[i+1] = acc[i] - pp;
    end else begin : g_pos
      assign acc[i+1] = acc[i] + pp;
    end
  end

  assign prod_o = acc[W];
endmodule

// File: rtl/exu_result_mux.sv
module exu_result_mux
  import exu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    and_i,
  input  logic [W-1:0]    or_i,
  input  logic [W-1:0]    xor_i,
  input  logic [W-1:0]    sum_i,
  input  logic [W-1:0]    prod_i,
  output logic [W-1:0]    res_o,
  output logic            legal_o
);
  always_comb begin
    res_o   = '0;
    legal_o = 1'b1;
    case (op_i)
      OP_AND:  res_o = and_i;
      OP_OR:   res_o = or_i;
      OP_XOR:  res_o = xor_i;
      OP_ADD:  res_o = sum_i;
      OP_MUL:  res_o = prod_i;
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned TW  = TAG_W,
  parameter int unsigned AW  = SUM_W,
  parameter int unsigned MW  = MUL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   rs_a_i,
  input  logic [DW-1:0]   imm_a_i,
  input  logic            use_imm_a_i,
  input  logic [DW-1:0]   rs_b_i,
  input  logic [DW-1:0]   imm_b_i,
  input  logic            use_imm_b_i,
  input  logic [TW-1:0]   dst_i,
  output logic [DW-1:0]   res_o,
  output logic [TW-1:0]   dst_o,
  output logic            vld_o
);
  localparam int unsigned EXT_W = AW - DW;
  localparam int unsigned PW    = 2 * MW;

  logic          rst_s_n;
  logic [DW-1:0] opa, opb;
  logic [DW-1:0] and_w, or_w, xor_w, res_w;
  logic [AW-1:0] sum_w;
  logic [PW-1:0] prod_w;
  logic          legal_w;

  logic [DW-1:0] res_d, res_q;
  logic [TW-1:0] dst_d, dst_q;
  logic          vld_d, vld_q;

  exu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  exu_operand_sel #(.W(DW)) u_sel_a (
    .reg_val_i(rs_a_i), .imm_val_i(imm_a_i), .use_imm_i(use_imm_a_i), .opnd_o(opa));
  exu_operand_sel #(.W(DW)) u_sel_b (
    .reg_val_i(rs_b_i), .imm_val_i(imm_b_i), .use_imm_i(use_imm_b_i), .opnd_o(opb));

  exu_logic_unit #(.W(DW)) u_logic (
    .a_i(opa), .b_i(opb), .and_o(and_w), .or_o(or_w), .xor_o(xor_w));

  exu_ripple_adder #(.W(AW)) u_add (
    .a_i({{EXT_W{opa[DW-1]}}, opa}),
    .b_i({{EXT_W{opb[DW-1]}}, opb}),
    .sum_o(sum_w));

  exu_signed_mult #(.W(MW)) u_mul (
    .a_i(opa[MW-1:0]), .b_i(opb[MW-1:0]), .prod_o(prod_w));

  exu_result_mux #(.W(DW)) u_mux (
    .op_i(op_i), .and_i(and_w), .or_i(or_w), .xor_i(xor_w),
    .sum_i(sum_w[DW-1:0]), .prod_i(prod_w),
    .res_o(res_w), .legal_o(legal_w));

  // R4: two sign-extended operands leave the upper half of the wide sum as pure sign copies
  always_comb begin
    sum_ext_chk: assert ((sum_w[AW-1:DW] == '0) || (&sum_w[AW-1:DW]));
  end

  // Next state: the enable gates every field of the output register.
  always_comb begin
    if (en_i) begin
      res_d = res_w;
      dst_d = dst_i;
      vld_d = legal_w;
    end else begin
      res_d = res_q;
      dst_d = dst_q;
      vld_d = vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_q <= '0;
      dst_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      dst_q <= dst_d;
      vld_q <= vld_d;
    end
  end

  assign res_o = res_q;
  assign dst_o = dst_q;
  assign vld_o = vld_q;

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en_i |=> ($stable(res_o) && $stable(dst_o) && $stable(vld_o)));

  // R10
  tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    en_i |=> (dst_o == $past(dst_i)));

  // R8
  nop_slot_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && (op_i > OP_MUL)) |=> (!vld_o && (res_o == '0)));

  // R7
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && (op_i <= OP_MUL)) |=> vld_o);

  // R4
  add_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && (op_i == OP_ADD)) |=> (res_o == $past(opa + opb)));

  // R5
  mul_byte_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_i && (op_i == OP_MUL)) |=>
      (res_o == $past({{MW{opa[MW-1]}}, opa[MW-1:0]} * {{MW{opb[MW-1]}}, opb[MW-1:0]})));
endmodule

// File: tb/exu_top_tb.sv
module exu_top_tb;
  typedef struct packed {
    logic [2:0]  op;
    logic        sa;
    logic        sb;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] ia;
    logic [15:0] ib;
    logic [2:0]  dst;
    logic [15:0] exp_res;
    logic        exp_vld;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 1'b0, 16'hF0F0, 16'h3C3C, 16'h0000, 16'h0000, 3'd1, 16'h3030, 1'b1}, // R1
    '{3'd1, 1'b0, 1'b0, 16'hF000, 16'h000F, 16'h0000, 16'h0000, 3'd2, 16'hF00F, 1'b1}, // R2
    '{3'd2, 1'b0, 1'b0, 16'hAAAA, 16'hFFFF, 16'h0000, 16'h0000, 3'd3, 16'h5555, 1'b1}, // R3
    '{3'd3, 1'b0, 1'b0, 16'h1234, 16'h1111, 16'h0000, 16'h0000, 3'd4, 16'h2345, 1'b1}, // R4
    '{3'd3, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 3'd5, 16'h0000, 1'b1}, // R4 wrap
    '{3'd3, 1'b0, 1'b0, 16'h8000, 16'h8000, 16'h0000, 16'h0000, 3'd6, 16'h0000, 1'b1}, // R4 wrap
    '{3'd4, 1'b0, 1'b0, 16'h12FF, 16'h3402, 16'h0000, 16'h0000, 3'd7, 16'hFFFE, 1'b1}, // R5 -1*2
    '{3'd4, 1'b0, 1'b0, 16'h0080, 16'h0080, 16'h0000, 16'h0000, 3'd0, 16'h4000, 1'b1}, // R5 -128*-128
    '{3'd4, 1'b0, 1'b0, 16'h007F, 16'h0080, 16'h0000, 16'h0000, 3'd1, 16'hC080, 1'b1}, // R5 127*-128
    '{3'd3, 1'b1, 1'b0, 16'hDEAD, 16'h0005, 16'h0100, 16'h0000, 3'd2, 16'h0105, 1'b1}, // R6 imm A
    '{3'd0, 1'b0, 1'b1, 16'h00FF, 16'hFFFF, 16'h0000, 16'h0F0F, 3'd3, 16'h000F, 1'b1}, // R6 imm B
    '{3'd5, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 3'd2, 16'h0000, 1'b0}, // R8
    '{3'd7, 1'b0, 1'b0, 16'h1234, 16'h4321, 16'h0000, 16'h0000, 3'd6, 16'h0000, 1'b0}, // R8
    '{3'd2, 1'b1, 1'b1, 16'h5A5A, 16'hA5A5, 16'h1234, 16'h1234, 3'd4, 16'h0000, 1'b1}  // R6 both imm
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [2:0]  op;
  logic [15:0] rs_a, imm_a, rs_b, imm_b;
  logic        use_a, use_b;
  logic [2:0]  dst;
  logic [15:0] res;
  logic [2:0]  dst_q;
  logic        vld;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  exu_top u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .op_i(op),
    .rs_a_i(rs_a), .imm_a_i(imm_a), .use_imm_a_i(use_a),
    .rs_b_i(rs_b), .imm_b_i(imm_b), .use_imm_b_i(use_b),
    .dst_i(dst), .res_o(res), .dst_o(dst_q), .vld_o(vld));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] o, logic sa, logic sb, logic [15:0] a, logic [15:0] b,
                       logic [15:0] ia, logic [15:0] ib, logic [2:0] d, logic e);
    op = o; use_a = sa; use_b = sb; rs_a = a; rs_b = b; imm_a = ia; imm_b = ib; dst = d; en = e;
  endtask

  task automatic check_all(string req, logic [15:0] r, logic [2:0] d, logic v);
    check(req, {16'h0, r}, {16'h0, res});
    check(req, {29'h0, d}, {29'h0, dst_q});
    check(req, {31'h0, v}, {31'h0, vld});
  endtask

  task automatic expect_out(string req, logic [15:0] r, logic [2:0] d, logic v);
    check(req, {16'h0, res},   {16'h0, r});
    check(req, {29'h0, dst_q}, {29'h0, d});
    check(req, {31'h0, vld},   {31'h0, v});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(3'd3, 1'b0, 1'b0, 16'h1111, 16'h2222, 16'h0, 16'h0, 3'd7, 1'b1);
    repeat (3) @(negedge clk);
    expect_out("R11 reset state", 16'h0000, 3'd0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: drive at a falling edge, capture on the rising edge, sample at the next fall
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].op, VECS[i].sa, VECS[i].sb, VECS[i].a, VECS[i].b,
            VECS[i].ia, VECS[i].ib, VECS[i].dst, 1'b1);
      @(negedge clk);
      expect_out($sformatf("R7 R10 vector %0d", i), VECS[i].exp_res, VECS[i].dst, VECS[i].exp_vld);
    end

    // R9: enable low while new legal operations arrive
    drive(3'd3, 1'b0, 1'b0, 16'h0001, 16'h0002, 16'h0, 16'h0, 3'd5, 1'b1);
    @(negedge clk);
    expect_out("R7 load before hold", 16'h0003, 3'd5, 1'b1);
    drive(3'd2, 1'b0, 1'b0, 16'hFFFF, 16'h0F0F, 16'h0, 16'h0, 3'd1, 1'b0);
    @(negedge clk);
    expect_out("R9 hold 1", 16'h0003, 3'd5, 1'b1);
    drive(3'd6, 1'b1, 1'b1, 16'h0, 16'h0, 16'h7777, 16'h7777, 3'd2, 1'b0);
    @(negedge clk);
    expect_out("R9 hold over nop", 16'h0003, 3'd5, 1'b1);

    // R8 then R9: a held no-operation slot stays invalid
    drive(3'd6, 1'b0, 1'b0, 16'hAAAA, 16'h5555, 16'h0, 16'h0, 3'd3, 1'b1);
    @(negedge clk);
    expect_out("R8 nop clears", 16'h0000, 3'd3, 1'b0);
    drive(3'd4, 1'b0, 1'b0, 16'h0003, 16'h0003, 16'h0, 16'h0, 3'd6, 1'b0);
    @(negedge clk);
    expect_out("R9 hold invalid", 16'h0000, 3'd3, 1'b0);

    // R5: upper operand bytes ignored
    drive(3'd4, 1'b0, 1'b0, 16'hFF03, 16'hAB05, 16'h0, 16'h0, 3'd4, 1'b1);
    @(negedge clk);
    expect_out("R5 high bytes ignored", 16'h000F, 3'd4, 1'b1);

    // R11: asynchronous reset mid-run over a valid held result
    drive(3'd1, 1'b0, 1'b0, 16'h0F00, 16'h00F0, 16'h0, 16'h0, 3'd7, 1'b0);
    #2 rst_n = 1'b0;
    #1 expect_out("R11 async reset", 16'h0000, 3'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    expect_out("R11 sync release 1", 16'h0000, 3'd0, 1'b0);
    @(negedge clk);
    expect_out("R11 sync release 2", 16'h0000, 3'd0, 1'b0);
    @(negedge clk);
    expect_out("R11 R2 after release", 16'h0FF0, 3'd7, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule